// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock of an SD/MMC host from its kernel clock. A divide field of `DIV_W` bits sets the length of each half period in kernel cycles. The same field, when zero, routes the kernel clock straight to the card. Beside the clock, the block produces two one-cycle strobes in the kernel domain. The launch strobe marks the card clock edge on which command and data outputs may change. The sample strobe marks the opposite edge, where inputs are captured. The polarity select decides which card clock edge is the launch edge. A registered one-hot decode reports the data bus width that is selected.

Two stop conditions park the card clock low. The first is power saving while the bus is idle. The second is a stall request while flow control is enabled. A stop never cuts a high phase short. A new divide value is adopted only when a new low phase begins, so changing the divider cannot produce a runt pulse.

Top module: `sd_card_clk_div`

## Requirements
- R1: With a nonzero divide value N, the card clock has a period of 2*N kernel cycles, of which N are high.
- R2: With a divide value of zero, the card clock follows the kernel clock and both strobes are high in every kernel cycle (outputs launched on the kernel falling edge). The negative-edge select has no effect in this mode.
- R3: With a nonzero divide value and `neg_edge` = 0, `launch_stb` is high for exactly the kernel cycles in which the card clock has just risen, and `sample_stb` for exactly those in which it has just fallen.
- R4: With a nonzero divide value and `neg_edge` = 1, the strobes are swapped: `launch_stb` marks the falling edges and `sample_stb` the rising edges.
- R5: `width_oh` is one-hot, one kernel cycle after its inputs: 3'b001 for a 1-bit bus, 3'b010 when only `width4_sel` is set, and 3'b100 whenever `width8_sel` is set (8-bit wins over 4-bit).
- R6: With `pwr_save` = 1 and `bus_busy` = 0, the card clock finishes any high phase and then stays low with both strobes low. It resumes at the normal rate once the bus is busy again.
- R7: With `flow_en` = 1 and `stall` = 1, the card clock is held low in the same way, in both divided and bypass mode. `stall` has no effect while `flow_en` = 0.
- R8: A divide value written during a high phase does not change that high phase. It takes effect from the next low phase onward.
- R9: While reset is asserted, the card clock and both strobes are low and `width_oh` is 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ker | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Half-period length in kernel cycles; 0 selects bypass |
| neg_edge | input | 1 | Launch on the falling card clock edge (divided mode only) |
| width4_sel | input | 1 | Select 4-bit data bus |
| width8_sel | input | 1 | Select 8-bit data bus |
| pwr_save | input | 1 | Stop the card clock while the bus is idle |
| flow_en | input | 1 | Allow `stall` to stop the card clock |
| bus_busy | input | 1 | Bus activity indicator |
| stall | input | 1 | Stop request from the data path |
| card_clk | output | 1 | Clock to the card |
| launch_stb | output | 1 | Kernel-cycle strobe for the launch edge |
| sample_stb | output | 1 | Kernel-cycle strobe for the sample edge |
| width_oh | output | 3 | One-hot bus width: {8-bit, 4-bit, 1-bit} |

## Verification
The divider is measured with divide values of 1, 2, 5 and the field maximum. The extremes separate an off-by-one error in the terminal count from a correct count. Across these values the period is checked to be double the high time. The strobes are compared edge by edge against the observed card clock with both polarity settings, which shows whether they are swapped or misplaced. Bypass is probed in both kernel clock phases with each polarity. A divider change is applied in the first cycle of a high phase, to confirm that it only reaches the next low phase. The stop conditions are tested in their enabling and non-enabling combinations, so that gating on the wrong input is detected.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

    typedef enum logic [2:0] {
        BUSW_1 = 3'b001,
        BUSW_4 = 3'b010,
        BUSW_8 = 3'b100
    } bus_width_e;

    function automatic bus_width_e decode_width(input logic sel4, input logic sel8);
        if (sel8)
            return BUSW_8;
        else if (sel4)
            return BUSW_4;
        return BUSW_1;
    endfunction

endpackage

// File: rtl/ckdiv_width_dec.sv
module ckdiv_width_dec
    import ckdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel4,
    input  logic       sel8,
    output logic [2:0] width_oh
);

    typedef struct packed {
        bus_width_e width;
    } wd_state_t;

    wd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.width = decode_width(sel4, sel8);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{width: BUSW_1};
        else
            st_q <= st_d;
    end

    assign width_oh = st_q.width;

endmodule

// File: rtl/ckdiv_core.sv
module ckdiv_core #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             stop,
    output logic             ck,
    output logic             rise,
    output logic             fall,
    output logic             bypass
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic             ck;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic             rise;
        logic             fall;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (st_q.div == '0) begin
            // bypass: keep the divided clock parked, track the field
            st_d.ck  = 1'b0;
            st_d.cnt = '0;
            st_d.div = div_val;
        end else if (!st_q.ck && stop) begin
            // parked in a low phase: safe point to adopt a new value
            st_d.cnt = '0;
            st_d.div = div_val;
        end else if (st_q.cnt == st_q.div - ONE) begin
            st_d.cnt = '0;
            st_d.ck  = ~st_q.ck;
            if (st_q.ck) begin
                st_d.fall = 1'b1;
                st_d.div  = div_val;   // new low phase begins
            end else begin
                st_d.rise = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign ck     = st_q.ck;
    assign rise   = st_q.rise;
    assign fall   = st_q.fall;
    assign bypass = (st_q.div == '0);

endmodule

// File: rtl/ckdiv_byp_gate.sv
module ckdiv_byp_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic gated_clk,
    output logic en_q
);

    logic en_d;

    always_comb en_d = enable;

    // enable updates only while the kernel clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= 1'b0;
        else
            en_q <= en_d;
    end

    assign gated_clk = clk & en_q;

endmodule

// File: rtl/sd_card_clk_div.sv
module sd_card_clk_div #(
    parameter int DIV_W = 10
) (
    input  logic             clk_ker,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             neg_edge,
    input  logic             width4_sel,
    input  logic             width8_sel,
    input  logic             pwr_save,
    input  logic             flow_en,
    input  logic             bus_busy,
    input  logic             stall,
    output logic             card_clk,
    output logic             launch_stb,
    output logic             sample_stb,
    output logic [2:0]       width_oh
);

    logic stop;
    logic div_ck, div_rise, div_fall, bypass;
    logic byp_clk, byp_en;

    assign stop = (pwr_save & ~bus_busy) | (flow_en & stall);

    ckdiv_core #(.DIV_W(DIV_W)) u_core (
        .clk    (clk_ker),
        .rst_n  (rst_n),
        .div_val(div_val),
        .stop   (stop),
        .ck     (div_ck),
        .rise   (div_rise),
        .fall   (div_fall),
        .bypass (bypass)
    );

    ckdiv_byp_gate u_byp (
        .clk      (clk_ker),
        .rst_n    (rst_n),
        .enable   (bypass & ~stop),
        .gated_clk(byp_clk),
        .en_q     (byp_en)
    );

    ckdiv_width_dec u_wdec (
        .clk     (clk_ker),
        .rst_n   (rst_n),
        .sel4    (width4_sel),
        .sel8    (width8_sel),
        .width_oh(width_oh)
    );

    always_comb begin
        if (bypass) begin
            card_clk   = byp_clk;
            launch_stb = byp_en;
            sample_stb = byp_en;
        end else begin
            card_clk   = div_ck;
            launch_stb = neg_edge ? div_fall : div_rise;
            sample_stb = neg_edge ? div_rise : div_fall;
        end
    end

endmodule

// File: rtl/sd_card_clk_div_chk.sv
module sd_card_clk_div_chk (
    input logic       clk_ker,
    input logic       rst_n,
    input logic       neg_edge,
    input logic       pwr_save,
    input logic       bus_busy,
    input logic       flow_en,
    input logic       stall,
    input logic       card_clk,
    input logic       launch_stb,
    input logic       sample_stb,
    input logic [2:0] width_oh,
    input logic       bypass
);

    AST_STROBE_EXCL: assert property (@(posedge clk_ker) disable iff (!rst_n)
        !bypass |-> !(launch_stb && sample_stb)); // R3

    AST_RISE_LAUNCH: assert property (@(posedge clk_ker) disable iff (!rst_n)
        (!bypass && $past(!bypass) && !neg_edge && $rose(card_clk)) |-> launch_stb); // R3

    AST_FALL_LAUNCH: assert property (@(posedge clk_ker) disable iff (!rst_n)
        (!bypass && $past(!bypass) && neg_edge && $fell(card_clk)) |-> launch_stb); // R4

    AST_WIDTH_ONEHOT: assert property (@(posedge clk_ker) disable iff (!rst_n)
        $countones(width_oh) == 1); // R5

    AST_PARK_LOW: assert property (@(posedge clk_ker) disable iff (!rst_n)
        (!bypass && !card_clk && pwr_save && !bus_busy) |=> !card_clk); // R6

    AST_STALL_LOW: assert property (@(posedge clk_ker) disable iff (!rst_n)
        (!bypass && !card_clk && flow_en && stall) |=> !card_clk); // R7

endmodule

bind sd_card_clk_div sd_card_clk_div_chk u_chk (
    .clk_ker   (clk_ker),
    .rst_n     (rst_n),
    .neg_edge  (neg_edge),
    .pwr_save  (pwr_save),
    .bus_busy  (bus_busy),
    .flow_en   (flow_en),
    .stall     (stall),
    .card_clk  (card_clk),
    .launch_stb(launch_stb),
    .sample_stb(sample_stb),
    .width_oh  (width_oh),
    .bypass    (bypass)
);

// File: tb/tb_sd_card_clk_div.sv
module tb_sd_card_clk_div;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 10;

    logic             clk_ker = 1'b0;
    logic             rst_n   = 1'b0;
    logic [DIV_W-1:0] div_val = 10'd2;
    logic             neg_edge = 1'b0;
    logic             width4_sel = 1'b0, width8_sel = 1'b0;
    logic             pwr_save = 1'b0, flow_en = 1'b0;
    logic             bus_busy = 1'b1, stall = 1'b0;
    logic             card_clk, launch_stb, sample_stb;
    logic [2:0]       width_oh;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk_ker = ~clk_ker;

    sd_card_clk_div #(.DIV_W(DIV_W)) dut (
        .clk_ker(clk_ker), .rst_n(rst_n), .div_val(div_val), .neg_edge(neg_edge),
        .width4_sel(width4_sel), .width8_sel(width8_sel), .pwr_save(pwr_save),
        .flow_en(flow_en), .bus_busy(bus_busy), .stall(stall), .card_clk(card_clk),
        .launch_stb(launch_stb), .sample_stb(sample_stb), .width_oh(width_oh)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_ker);
        #1;
    endtask

    // Measure one high phase and the following low phase, sampled at negedges.
    // If new_div >= 0 it is applied right after the rise is seen.
    task automatic measure(output int hi, output int lo, input int new_div);
        logic p;
        bit   seen = 0;
        @(negedge clk_ker);
        p = card_clk;
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk_ker);
            if (card_clk && !p) begin seen = 1; break; end
            p = card_clk;
        end
        if (new_div >= 0) begin #1; div_val = DIV_W'(new_div); end
        hi = seen ? 1 : 0;
        lo = 0;
        if (!seen) return;
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk_ker);
            if (!card_clk) break;
            hi++;
        end
        for (int g = 0; g < 5000; g++) begin
            lo++;
            @(negedge clk_ker);
            if (card_clk) break;
        end
    endtask

    task automatic t_reset();
        @(negedge clk_ker);
        check(card_clk == 0 && launch_stb == 0 && sample_stb == 0, "R9",
              "outputs low in reset", {card_clk, launch_stb, sample_stb}, 0);
        check(width_oh == 3'b001, "R9", "width in reset", width_oh, 1);
        #1 rst_n = 1'b1;
    endtask

    task automatic t_period(input int n);
        int hi, lo;
        #1 div_val = DIV_W'(n);
        measure(hi, lo, -1);
        measure(hi, lo, -1);
        check(hi == n, "R1", $sformatf("high time div=%0d", n), hi, n);
        check(hi + lo == 2 * n, "R1", $sformatf("period div=%0d", n), hi + lo, 2 * n);
    endtask

    task automatic t_strobes(input bit neg);
        logic p;
        int bad = 0;
        int hi, lo;
        #1 neg_edge = neg; div_val = 10'd3;
        measure(hi, lo, -1);
        p = card_clk;
        for (int i = 0; i < 40; i++) begin
            logic r, f;
            @(negedge clk_ker);
            r = card_clk && !p;
            f = !card_clk && p;
            if (launch_stb !== (neg ? f : r) || sample_stb !== (neg ? r : f)) bad++;
            p = card_clk;
        end
        if (neg) check(bad == 0, "R4", "strobes on swapped edges", bad, 0);
        else     check(bad == 0, "R3", "strobes on card clock edges", bad, 0);
        #1 neg_edge = 1'b0;
    endtask

    task automatic t_bypass();
        #1 div_val = 10'd0;
        drive_cycles(10);
        for (int k = 0; k < 2; k++) begin
            #1 neg_edge = k[0];
            @(posedge clk_ker); #2;
            check(card_clk == 1, "R2", "bypass clock high phase", card_clk, 1);
            check(launch_stb == 1 && sample_stb == 1, "R2",
                  $sformatf("bypass strobes neg=%0d", k), {launch_stb, sample_stb}, 3);
            @(negedge clk_ker); #2;
            check(card_clk == 0, "R2", "bypass clock low phase", card_clk, 0);
        end
        #1 neg_edge = 1'b0;
        div_val = 10'd2;
        drive_cycles(6);
    endtask

    task automatic t_width();
        logic [2:0] exp [4] = '{3'b001, 3'b010, 3'b100, 3'b100};
        for (int k = 0; k < 4; k++) begin
            #1 width4_sel = k[0]; width8_sel = k[1];
            drive_cycles(2);
            check(width_oh == exp[k], "R5", $sformatf("width sel=%0d", k), width_oh, exp[k]);
        end
        #1 width4_sel = 0; width8_sel = 0;
    endtask

    task automatic t_gate(input bit use_stall);
        int active = 0;
        int hi, lo;
        #1 div_val = 10'd2;
        drive_cycles(8);
        if (use_stall) begin flow_en = 1; stall = 1; end
        else begin pwr_save = 1; bus_busy = 0; end
        drive_cycles(6);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_ker);
            if (card_clk || launch_stb || sample_stb) active++;
        end
        check(active == 0, use_stall ? "R7" : "R6", "clock parked low", active, 0);
        #1;
        if (use_stall) stall = 0; else bus_busy = 1;
        measure(hi, lo, -1);
        check(hi == 2 && lo == 2, use_stall ? "R7" : "R6", "resume rate", hi + lo, 4);
        #1 pwr_save = 0; flow_en = 0; bus_busy = 1; stall = 0;
    endtask

    task automatic t_stall_ignored_and_bypass();
        int hi, lo;
        #1 flow_en = 0; stall = 1;
        measure(hi, lo, -1);
        check(hi == 2 && lo == 2, "R7", "stall ignored without flow control", hi + lo, 4);
        #1 div_val = 10'd0;
        drive_cycles(10);
        flow_en = 1;
        drive_cycles(2);
        @(posedge clk_ker); #2;
        check(card_clk == 0, "R7", "bypass clock stalled", card_clk, 0);
        #1 flow_en = 0; stall = 0; div_val = 10'd4;
        drive_cycles(10);
    endtask

    task automatic t_div_change();
        int hi, lo, hi2, lo2;
        #1 div_val = 10'd4;
        measure(hi, lo, -1);
        measure(hi, lo, 1);
        check(hi == 4, "R8", "high phase keeps old divide", hi, 4);
        check(lo == 1, "R8", "next low phase uses new divide", lo, 1);
        measure(hi2, lo2, -1);
        check(hi2 == 1 && lo2 == 1, "R8", "new divide settled", hi2 + lo2, 2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        drive_cycles(3);
        t_reset();
        drive_cycles(4);
        t_period(2);
        t_period(1);
        t_period(5);
        t_period(1023);
        t_strobes(1'b0);
        t_strobes(1'b1);
        t_bypass();
        t_width();
        t_gate(1'b0);
        t_gate(1'b1);
        t_stall_ignored_and_bypass();
        t_div_change();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule